// File: doc/BRIEF.md
# Four-Bank Interleaved Shared SRAM Arbiter

This block puts one on-chip SRAM behind three masters: a processor port that moves 64 bits per beat, and two DMA ports that move 32 bits per beat. The storage is four independent 32-bit banks. Consecutive 32-bit words sit in consecutive banks, and each bank has its own arbiter. Two masters that want different banks are therefore both served in the same cycle.

Because arbitration happens per bank, a lower-priority burst does not wait for a higher-priority transfer to finish. It enters a bank in the cycle after the stronger master has moved past that bank. A processor transfer of 128 bits is issued as two 64-bit beats: the first beat covers banks 0 and 1, the second covers banks 2 and 3. A DMA burst that targets bank 0 is granted in the same cycle as the second processor beat.

Each port has a valid/ready request channel and a read-data return channel. A mode input selects fixed priority or round-robin rotation. The mode applies to all banks.

Top module: `banked_sram_arb`

## Requirements
- R1: A DMA word address w selects bank w mod 4 and row w div 4. A processor beat address d covers the words 2d (bits 31:0 of the beat) and 2d+1 (bits 63:32 of the beat). With d even the beat uses banks 0 and 1; with d odd it uses banks 2 and 3.
- R2: Requests that target different banks are all granted (ready high) in the same cycle. A port with valid low sees ready low.
- R3: With rr_mode low, a bank that several ports request goes to the processor first, then DMA0, then DMA1.
- R4: A processor beat is granted only when it wins both of its banks. If it loses either bank, processor ready is low. Both of its banks are then arbitrated among the DMA ports alone, as if the processor had not asked.
- R5: A request whose ready is low has no effect. No write reaches the memory, and no read data is returned for it.
- R6: Each bank keeps the index of the port it last granted (0 processor, 1 DMA0, 2 DMA1). Reset sets this index to 2. The index is updated on every grant in either mode and is otherwise held. With rr_mode high, the search order after last index k is k+1, then k+2, then k, taken modulo 3.
- R7: A granted read raises the port's rvalid exactly one cycle after the grant cycle. A granted write and a refused request raise no rvalid. All rvalid outputs are low during and right after reset.
- R8: Read data equals the most recent granted write to the same word or words. The processor's rdata places word 2d in bits 31:0.
- R9: In fixed mode, suppose the processor issues beats to d=0 and then d=1 while DMA0 and DMA1 both start bursts at word 0. DMA0 is first granted in the processor's second cycle. DMA1 is first granted one cycle after DMA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_mode | input | 1 | 0 selects fixed priority, 1 selects round-robin |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Processor beat granted this cycle |
| cpu_addr | input | ADDR_W-1 | Processor 64-bit beat address |
| cpu_we | input | 1 | Processor write enable |
| cpu_wdata | input | 64 | Processor write data |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | 64 | Processor read data |
| dma0_valid | input | 1 | DMA0 request valid |
| dma0_ready | output | 1 | DMA0 granted this cycle |
| dma0_addr | input | ADDR_W | DMA0 word address |
| dma0_we | input | 1 | DMA0 write enable |
| dma0_wdata | input | 32 | DMA0 write data |
| dma0_rvalid | output | 1 | DMA0 read data valid |
| dma0_rdata | output | 32 | DMA0 read data |
| dma1_valid | input | 1 | DMA1 request valid |
| dma1_ready | output | 1 | DMA1 granted this cycle |
| dma1_addr | input | ADDR_W | DMA1 word address |
| dma1_we | input | 1 | DMA1 write enable |
| dma1_wdata | input | 32 | DMA1 write data |
| dma1_rvalid | output | 1 | DMA1 read data valid |
| dma1_rdata | output | 32 | DMA1 read data |

## Verification
The bench targets the processor losing exactly one of its two banks under round-robin. A design that grants half a beat, or that leaves the lost bank's partner idle, would show the wrong ready pattern or corrupt memory on a later read-back.

It replays the staggered-burst case. A design that arbitrates the whole memory as one unit would hold DMA1 off for several extra cycles.

It also checks these cases:
- Round-robin alternation on a single contested bank, where a pointer that moves without a grant would break the alternation.
- A stalled DMA write that is later withdrawn. A design that writes before the grant would overwrite the preloaded word.
- Random mixed traffic in both modes, compared against a reference memory and arbitration model.

// File: rtl/banked_sram_pkg.sv
package banked_sram_pkg;

    localparam int NUM_BANKS = 4;
    localparam int NUM_PORTS = 3;
    localparam int WORD_W    = 32;

    localparam int P_CPU  = 0;
    localparam int P_DMA0 = 1;
    localparam int P_DMA1 = 2;

    typedef logic [NUM_PORTS-1:0] port_vec_t;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [WORD_W-1:0] wdata;
    } bank_cmd_t;

    // One-hot winner: fixed order 0,1,2 or rotation starting after last.
    function automatic port_vec_t pick_winner(port_vec_t req, logic rr, logic [1:0] last);
        port_vec_t g;
        g = '0;
        if (!rr) begin
            if (req[P_CPU])       g[P_CPU]  = 1'b1;
            else if (req[P_DMA0]) g[P_DMA0] = 1'b1;
            else if (req[P_DMA1]) g[P_DMA1] = 1'b1;
        end else begin
            for (int k = 1; k <= NUM_PORTS; k++) begin
                int idx;
                idx = (int'(last) + k) % NUM_PORTS;
                if (g == '0 && req[idx]) g[idx] = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic logic [1:0] vec_to_id(port_vec_t v);
        if (v[P_DMA1])      return 2'd2;
        else if (v[P_DMA0]) return 2'd1;
        else                return 2'd0;
    endfunction

endpackage

// File: rtl/bank_arb.sv
module bank_arb
    import banked_sram_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rr,
    input  port_vec_t req,
    input  logic      cpu_drop,
    output port_vec_t pref,
    output port_vec_t grant
);

    logic [1:0] last_q;
    port_vec_t  req_eff;

    always_comb begin
        req_eff = req;
        if (cpu_drop) req_eff[P_CPU] = 1'b0;
        pref  = pick_winner(req, rr, last_q);
        grant = pick_winner(req_eff, rr, last_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= 2'd2;
        else if (grant != '0)
            last_q <= vec_to_id(grant);
    end

    // R3: fixed mode gives the bank to the strongest surviving requester
    a_r3_fixed_cpu_first: assert property (@(posedge clk) disable iff (rst)
        (!rr && req_eff[P_CPU]) |-> grant[P_CPU]);
    a_r3_fixed_dma0_over_dma1: assert property (@(posedge clk) disable iff (rst)
        (!rr && !req_eff[P_CPU] && req_eff[P_DMA0]) |-> grant[P_DMA0]);

    // R2: a bank with any surviving requester is never left idle
    a_r2_bank_busy: assert property (@(posedge clk) disable iff (rst)
        (req_eff != '0) |-> (grant != '0));

    // R6: pointer moves only on a grant
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) |=> $stable(last_q));

    a_r2_single_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/sram_bank.sv
module sram_bank
    import banked_sram_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ROW_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[row] <= wdata;
            else    rdata_q  <= mem[row];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/banked_sram_arb.sv
module banked_sram_arb
    import banked_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rr_mode,
    input  logic                cpu_valid,
    output logic                cpu_ready,
    input  logic [ADDR_W-2:0]   cpu_addr,
    input  logic                cpu_we,
    input  logic [2*WORD_W-1:0] cpu_wdata,
    output logic                cpu_rvalid,
    output logic [2*WORD_W-1:0] cpu_rdata,
    input  logic                dma0_valid,
    output logic                dma0_ready,
    input  logic [ADDR_W-1:0]   dma0_addr,
    input  logic                dma0_we,
    input  logic [WORD_W-1:0]   dma0_wdata,
    output logic                dma0_rvalid,
    output logic [WORD_W-1:0]   dma0_rdata,
    input  logic                dma1_valid,
    output logic                dma1_ready,
    input  logic [ADDR_W-1:0]   dma1_addr,
    input  logic                dma1_we,
    input  logic [WORD_W-1:0]   dma1_wdata,
    output logic                dma1_rvalid,
    output logic [WORD_W-1:0]   dma1_rdata
);

    localparam int ROW_W  = ADDR_W - 2;
    localparam int BSEL_W = $clog2(NUM_BANKS);

    // address split
    logic              cpu_hi;
    logic [ROW_W-1:0]  cpu_row, d0_row, d1_row;
    logic [BSEL_W-1:0] cpu_lo_bank, cpu_up_bank, d0_bank, d1_bank;

    assign cpu_hi      = cpu_addr[0];
    assign cpu_row     = cpu_addr[ADDR_W-2:1];
    assign cpu_lo_bank = {cpu_hi, 1'b0};
    assign cpu_up_bank = {cpu_hi, 1'b1};
    assign d0_bank     = dma0_addr[BSEL_W-1:0];
    assign d1_bank     = dma1_addr[BSEL_W-1:0];
    assign d0_row      = dma0_addr[ADDR_W-1:BSEL_W];
    assign d1_row      = dma1_addr[ADDR_W-1:BSEL_W];

    port_vec_t         req_b   [NUM_BANKS];
    port_vec_t         pref_b  [NUM_BANKS];
    port_vec_t         grant_b [NUM_BANKS];
    logic [WORD_W-1:0] rd_b    [NUM_BANKS];
    logic              cpu_ok;

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            req_b[b][P_CPU]  = cpu_valid  && (cpu_hi == 1'(b >> 1));
            req_b[b][P_DMA0] = dma0_valid && (d0_bank == BSEL_W'(b));
            req_b[b][P_DMA1] = dma1_valid && (d1_bank == BSEL_W'(b));
        end
    end

    // processor beat needs both halves of its bank pair
    assign cpu_ok = cpu_valid && pref_b[cpu_lo_bank][P_CPU] && pref_b[cpu_up_bank][P_CPU];

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        bank_cmd_t        cmd;
        logic [ROW_W-1:0] row;

        bank_arb u_arb (
            .clk      (clk),
            .rst      (rst),
            .rr       (rr_mode),
            .req      (req_b[gb]),
            .cpu_drop (!cpu_ok),
            .pref     (pref_b[gb]),
            .grant    (grant_b[gb])
        );

        always_comb begin
            cmd = '0;
            row = '0;
            if (grant_b[gb][P_CPU]) begin
                cmd.en    = 1'b1;
                cmd.we    = cpu_we;
                cmd.wdata = (gb % 2 == 1) ? cpu_wdata[2*WORD_W-1:WORD_W] : cpu_wdata[WORD_W-1:0];
                row       = cpu_row;
            end else if (grant_b[gb][P_DMA0]) begin
                cmd.en    = 1'b1;
                cmd.we    = dma0_we;
                cmd.wdata = dma0_wdata;
                row       = d0_row;
            end else if (grant_b[gb][P_DMA1]) begin
                cmd.en    = 1'b1;
                cmd.we    = dma1_we;
                cmd.wdata = dma1_wdata;
                row       = d1_row;
            end
        end

        sram_bank #(.ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .en    (cmd.en),
            .we    (cmd.we),
            .row   (row),
            .wdata (cmd.wdata),
            .rdata (rd_b[gb])
        );
    end

    assign cpu_ready  = cpu_ok;
    assign dma0_ready = grant_b[d0_bank][P_DMA0];
    assign dma1_ready = grant_b[d1_bank][P_DMA1];

    // read return tags
    logic              cpu_rv_q, d0_rv_q, d1_rv_q;
    logic              cpu_pair_q;
    logic [BSEL_W-1:0] d0_bank_q, d1_bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rv_q   <= 1'b0;
            d0_rv_q    <= 1'b0;
            d1_rv_q    <= 1'b0;
            cpu_pair_q <= 1'b0;
            d0_bank_q  <= '0;
            d1_bank_q  <= '0;
        end else begin
            cpu_rv_q   <= cpu_ok && !cpu_we;
            d0_rv_q    <= dma0_ready && !dma0_we;
            d1_rv_q    <= dma1_ready && !dma1_we;
            cpu_pair_q <= cpu_hi;
            d0_bank_q  <= d0_bank;
            d1_bank_q  <= d1_bank;
        end
    end

    assign cpu_rvalid  = cpu_rv_q;
    assign dma0_rvalid = d0_rv_q;
    assign dma1_rvalid = d1_rv_q;
    assign cpu_rdata   = {rd_b[{cpu_pair_q, 1'b1}], rd_b[{cpu_pair_q, 1'b0}]};
    assign dma0_rdata  = rd_b[d0_bank_q];
    assign dma1_rdata  = rd_b[d1_bank_q];

    // R4: a granted beat owns both of its banks
    a_r4_pair_owned: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> (grant_b[cpu_lo_bank][P_CPU] && grant_b[cpu_up_bank][P_CPU]));
    // R4: a refused beat touches no bank
    a_r4_no_half_beat: assert property (@(posedge clk) disable iff (rst)
        !cpu_ready |-> !(grant_b[0][P_CPU] || grant_b[1][P_CPU] || grant_b[2][P_CPU] || grant_b[3][P_CPU]));
    // R2: two DMA grants in one cycle are on different banks
    a_r2_dma_distinct: assert property (@(posedge clk) disable iff (rst)
        (dma0_ready && dma1_ready) |-> (d0_bank != d1_bank));
    // R7: read returns one cycle after grant, writes return nothing
    a_r7_cpu_read_lat: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_ready && !cpu_we) |=> cpu_rvalid);
    a_r7_cpu_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!(cpu_valid && cpu_ready && !cpu_we)) |=> !cpu_rvalid);
    a_r7_dma0_read_lat: assert property (@(posedge clk) disable iff (rst)
        (dma0_valid && dma0_ready && !dma0_we) |=> dma0_rvalid);
    a_r7_dma1_read_lat: assert property (@(posedge clk) disable iff (rst)
        (dma1_valid && dma1_ready && !dma1_we) |=> dma1_rvalid);
    // R5: refused DMA request returns no data
    a_r5_dma1_refused_quiet: assert property (@(posedge clk) disable iff (rst)
        !dma1_ready |=> !dma1_rvalid);

endmodule

// File: tb/tb_banked_sram_arb.sv
`timescale 1ns/1ps
module tb_banked_sram_arb;

    localparam int AW    = 10;
    localparam int WORDS = 1 << AW;

    logic        clk = 1'b0;
    logic        rst;
    logic        rr;
    logic        cv, cwe;
    logic [AW-2:0] ca;
    logic [63:0] cwd;
    logic        dv  [2];
    logic [AW-1:0] da [2];
    logic        dwe [2];
    logic [31:0] dwd [2];

    logic        cpu_ready, cpu_rvalid, dma0_ready, dma0_rvalid, dma1_ready, dma1_rvalid;
    logic [63:0] cpu_rdata;
    logic [31:0] dma0_rdata, dma1_rdata;

    banked_sram_arb #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .rr_mode(rr),
        .cpu_valid(cv), .cpu_ready(cpu_ready), .cpu_addr(ca), .cpu_we(cwe), .cpu_wdata(cwd),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .dma0_valid(dv[0]), .dma0_ready(dma0_ready), .dma0_addr(da[0]), .dma0_we(dwe[0]),
        .dma0_wdata(dwd[0]), .dma0_rvalid(dma0_rvalid), .dma0_rdata(dma0_rdata),
        .dma1_valid(dv[1]), .dma1_ready(dma1_ready), .dma1_addr(da[1]), .dma1_we(dwe[1]),
        .dma1_wdata(dwd[1]), .dma1_rvalid(dma1_rvalid), .dma1_rdata(dma1_rdata)
    );

    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] mdl [WORDS];
    int          lastp [4];
    logic        exp_rdy [3];
    logic        act_rdy [3];
    logic        exp_crv;
    logic [63:0] exp_crd;
    logic        exp_drv [2];
    logic [31:0] exp_drd [2];

    function automatic logic [31:0] pat(int w);
        return 32'hA500_0000 ^ (32'(w) * 32'h0001_0103);
    endfunction

    function automatic int sel(logic [2:0] rq, logic rrm, int lst);
        if (!rrm) begin
            for (int i = 0; i < 3; i++) if (rq[i]) return i;
        end else begin
            for (int k = 1; k <= 3; k++) if (rq[(lst + k) % 3]) return (lst + k) % 3;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        cv = 0; cwe = 0; ca = '0; cwd = '0;
        for (int p = 0; p < 2; p++) begin dv[p] = 0; dwe[p] = 0; da[p] = '0; dwd[p] = '0; end
    endtask

    // Called just after inputs are driven at a falling edge; returns at the next falling edge.
    task automatic do_cycle();
        logic [2:0] rq [4];
        int         w1 [4];
        int         w2 [4];
        bit         ok;
        int         lo;
        #2;
        chk(cpu_rvalid === exp_crv, "R7 cpu rvalid", 64'(cpu_rvalid), 64'(exp_crv));
        if (exp_crv) chk(cpu_rdata === exp_crd, "R8 R1 cpu rdata", cpu_rdata, exp_crd);
        chk(dma0_rvalid === exp_drv[0], "R7 dma0 rvalid", 64'(dma0_rvalid), 64'(exp_drv[0]));
        if (exp_drv[0]) chk(dma0_rdata === exp_drd[0], "R8 dma0 rdata", 64'(dma0_rdata), 64'(exp_drd[0]));
        chk(dma1_rvalid === exp_drv[1], "R7 dma1 rvalid", 64'(dma1_rvalid), 64'(exp_drv[1]));
        if (exp_drv[1]) chk(dma1_rdata === exp_drd[1], "R8 dma1 rdata", 64'(dma1_rdata), 64'(exp_drd[1]));

        act_rdy[0] = cpu_ready; act_rdy[1] = dma0_ready; act_rdy[2] = dma1_ready;

        for (int b = 0; b < 4; b++) begin
            rq[b][0] = cv && (int'(ca[0]) == b / 2);
            rq[b][1] = dv[0] && (int'(da[0][1:0]) == b);
            rq[b][2] = dv[1] && (int'(da[1][1:0]) == b);
            w1[b] = sel(rq[b], rr, lastp[b]);
        end
        lo = ca[0] ? 2 : 0;
        ok = cv && (w1[lo] == 0) && (w1[lo+1] == 0);
        for (int b = 0; b < 4; b++) begin
            logic [2:0] r;
            r = rq[b];
            if (!ok) r[0] = 1'b0;
            w2[b] = sel(r, rr, lastp[b]);
        end
        exp_rdy[0] = ok;
        exp_rdy[1] = dv[0] && (w2[da[0][1:0]] == 1);
        exp_rdy[2] = dv[1] && (w2[da[1][1:0]] == 2);
        chk(act_rdy[0] === exp_rdy[0], "R2 R3 R4 R6 cpu ready", 64'(act_rdy[0]), 64'(exp_rdy[0]));
        chk(act_rdy[1] === exp_rdy[1], "R2 R3 R4 R6 dma0 ready", 64'(act_rdy[1]), 64'(exp_rdy[1]));
        chk(act_rdy[2] === exp_rdy[2], "R2 R3 R4 R6 dma1 ready", 64'(act_rdy[2]), 64'(exp_rdy[2]));

        exp_crv = ok && !cwe;
        if (exp_crv) exp_crd = {mdl[2*int'(ca)+1], mdl[2*int'(ca)]};
        for (int p = 0; p < 2; p++) begin
            exp_drv[p] = exp_rdy[p+1] && !dwe[p];
            if (exp_drv[p]) exp_drd[p] = mdl[int'(da[p])];
        end
        if (ok && cwe) begin
            mdl[2*int'(ca)]   = cwd[31:0];
            mdl[2*int'(ca)+1] = cwd[63:32];
        end
        for (int p = 0; p < 2; p++)
            if (exp_rdy[p+1] && dwe[p]) mdl[int'(da[p])] = dwd[p];
        for (int b = 0; b < 4; b++) if (w2[b] >= 0) lastp[b] = w2[b];
        @(negedge clk);
    endtask

    task automatic hand(input logic c, input logic d0, input logic d1, input string tag);
        chk(act_rdy[0] === c,  {tag, " cpu ready"},  64'(act_rdy[0]), 64'(c));
        chk(act_rdy[1] === d0, {tag, " dma0 ready"}, 64'(act_rdy[1]), 64'(d0));
        chk(act_rdy[2] === d1, {tag, " dma1 ready"}, 64'(act_rdy[2]), 64'(d1));
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int w = 0; w < WORDS; w++) mdl[w] = '0;
        for (int b = 0; b < 4; b++) lastp[b] = 2;
        exp_crv = 0; exp_crd = '0;
        for (int p = 0; p < 2; p++) begin exp_drv[p] = 0; exp_drd[p] = '0; end
        rst = 1; rr = 0;
        idle_all();
        repeat (3) @(negedge clk);
        #2;
        chk(cpu_rvalid === 1'b0, "R7 reset cpu rvalid", 64'(cpu_rvalid), 64'd0);
        chk(dma0_rvalid === 1'b0 && dma1_rvalid === 1'b0, "R7 reset dma rvalid",
            64'({dma0_rvalid, dma1_rvalid}), 64'd0);
        chk(cpu_ready === 1'b0 && dma0_ready === 1'b0 && dma1_ready === 1'b0, "R2 idle ready low",
            64'({cpu_ready, dma0_ready, dma1_ready}), 64'd0);
        @(negedge clk);
        rst = 0;

        // R6 / R4: round-robin from reset pointers, all writes
        rr = 1;
        cv = 1; cwe = 1; ca = 9'd0; cwd = 64'h1111_0000_2222_0000;
        do_cycle(); hand(1, 0, 0, "R6 rr first");
        dv[0] = 1; dwe[0] = 1; da[0] = 10'd0; dwd[0] = 32'h0D00;
        dv[1] = 1; dwe[1] = 1; da[1] = 10'd1; dwd[1] = 32'h0D11;
        do_cycle(); hand(0, 1, 1, "R4 cpu loses pair");
        dv[0] = 0; dv[1] = 0;
        do_cycle(); hand(1, 0, 0, "R4 R6 cpu retry wins");
        cv = 0;
        dv[0] = 1; da[0] = 10'd8; dv[1] = 1; da[1] = 10'd4;
        do_cycle(); hand(0, 1, 0, "R6 rr bank0 dma0");
        da[0] = 10'd12;
        do_cycle(); hand(0, 0, 1, "R6 rr bank0 dma1 turn");
        rr = 0; da[1] = 10'd16;
        do_cycle(); hand(0, 1, 0, "R3 fixed dma0 over dma1");
        da[0] = 10'd20;
        do_cycle(); hand(0, 1, 0, "R3 fixed ignores pointer");
        idle_all();
        do_cycle();

        // R9: staggered bursts behind a 128-bit processor transfer
        cv = 1; cwe = 1; ca = 9'd0; cwd = 64'hAAAA_0001_AAAA_0000;
        dv[0] = 1; dwe[0] = 1; da[0] = 10'd0; dwd[0] = 32'hB0;
        dv[1] = 1; dwe[1] = 1; da[1] = 10'd0; dwd[1] = 32'hC0;
        do_cycle(); hand(1, 0, 0, "R9 cycle0");
        ca = 9'd1;
        do_cycle(); hand(1, 1, 0, "R9 cycle1");
        cv = 0; da[0] = 10'd1;
        do_cycle(); hand(0, 1, 1, "R9 cycle2");
        da[0] = 10'd2; da[1] = 10'd1;
        do_cycle(); hand(0, 1, 1, "R9 cycle3");
        idle_all();
        do_cycle();

        // preload every word through DMA0
        for (int w = 0; w < WORDS; w++) begin
            dv[0] = 1; dwe[0] = 1; da[0] = AW'(w); dwd[0] = pat(w);
            do_cycle();
        end
        idle_all();
        do_cycle();

        // R5: stalled write that is withdrawn leaves the word untouched
        dv[0] = 1; dwe[0] = 1; da[0] = 10'd5; dwd[0] = 32'h5555_AAAA;
        dv[1] = 1; dwe[1] = 1; da[1] = 10'd9; dwd[1] = 32'hDEAD_BEEF;
        do_cycle(); hand(0, 1, 0, "R5 dma1 stalled");
        idle_all();
        do_cycle();
        chk(dma1_rvalid === 1'b0, "R5 stalled no return", 64'(dma1_rvalid), 64'd0);
        dv[0] = 1; dwe[0] = 0; da[0] = 10'd9;
        do_cycle();
        idle_all();
        #1;
        chk(dma0_rvalid === 1'b1 && dma0_rdata === pat(9), "R5 word unchanged",
            64'(dma0_rdata), 64'(pat(9)));
        do_cycle();

        // random mixed traffic, masters hold while stalled
        for (int c = 0; c < 3000; c++) begin
            if (c % 250 == 0) rr = ~rr;
            if (!cv || exp_rdy[0]) begin
                cv = ($urandom % 4) != 0; cwe = $urandom % 2;
                ca = (AW-1)'($urandom); cwd = {$urandom, $urandom};
            end
            for (int p = 0; p < 2; p++) begin
                if (!dv[p] || exp_rdy[p+1]) begin
                    dv[p] = ($urandom % 4) != 0; dwe[p] = $urandom % 2;
                    da[p] = AW'($urandom); dwd[p] = $urandom;
                end
            end
            do_cycle();
        end
        idle_all();
        do_cycle();
        do_cycle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule